// File: doc/BRIEF.md
# Parallel Bus Transmitter with Ready and Data-Enable Handshake

This block sends host data over a synchronous parallel bus, either one byte or one half-word per bus cycle. The host writes 32-bit words into a 16-byte queue, and the block sends each word lowest byte first. A data-enable output marks the bus cycles that carry a unit. A ready input from the receiver can stall a transfer. A stalled unit stays on the bus, with the enable active, until the receiver takes it.

The parallel clock is an input. It is oversampled by the system clock, which also drives the host write port. One configuration bit picks which parallel clock edge launches data; the other edge samples ready. The ready level and the enable level each have their own polarity bit. A two-bit field turns each handshake on or off.

A stall that comes just before the queue runs dry is handled exactly. No unit is ever first placed on the bus while the enable is inactive. When the queue is empty, the bus holds its last value, so nothing new can slip past the receiver unmarked.

Top module: `ptx_top`

## Requirements
- R1: While reset is held and right after it, `pd_out` is 0, `de_out` is at its inactive level (the inverse of `cfg_depol`), `room4` is 1 and `ovr` is 0.
- R2: With `cfg_ckpol` = 0, `pd_out` and `de_out` change only on a rising `pclk` edge, and `rdy_in` is taken on a falling edge. With `cfg_ckpol` = 1 the two edges swap. A change of `rdy_in` away from the sampling edge has no effect.
- R3: `de_out` and `pd_out` change on the same launch edge. `pd_out` never changes while the enable is inactive.
- R4: On a launch edge where no unit is waiting and the queue holds a whole unit (1 byte in byte mode, 2 bytes in half-word mode), that unit goes onto the bus with the enable active.
- R5: On a launch edge where nothing is waiting and no whole unit is queued, the enable goes inactive and `pd_out` keeps its value.
- R6: If the receiver is not ready at the sampling edge of a cycle whose enable was active, the same value is presented again with the enable active on the next launch edge. This repeats until the unit is accepted.
- R7: With `cfg_rdypol` = 0 a low `rdy_in` means ready, and with 1 a high level means ready. With `cfg_depol` = 0 a low `de_out` marks valid data, and with 1 a high level does.
- R8: `cfg_hs_en` bit 0 enables the ready input; when it is clear the receiver counts as always ready. Bit 1 enables the data-enable output; when it is clear, `de_out` stays at its inactive level.
- R9: The queue holds 16 bytes. `room4` is 1 exactly when at least 4 bytes are free.
- R10: A word is sent lowest byte first. In byte mode (`cfg_wide` = 0) each byte appears on `pd_out[7:0]` with `pd_out[15:8]` = 0. In half-word mode (`cfg_wide` = 1) bits 15:0 of the word go first, then bits 31:16.
- R11: A write made while `room4` is 0 is dropped, and `ovr` goes to 1 on the next clock. `ovr` stays at 1 until `ovr_clr` is pulsed. If a set and a clear come in the same cycle, the set wins.
- R12: When a stall lands one or two cycles before the queue runs dry, no unit is lost. Every unit is received once, in order, with the enable active.
- R13: While `cfg_en` is 0, no new unit is started and the enable stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples `pclk` and clocks host writes |
| rst_n | input | 1 | Synchronous active-low reset |
| pclk | input | 1 | Parallel bus clock from outside |
| cfg_en | input | 1 | Transmitter enable |
| cfg_ckpol | input | 1 | 0: launch on rising `pclk`, sample on falling; 1: swapped |
| cfg_rdypol | input | 1 | Level of `rdy_in` that means ready (0 = low) |
| cfg_depol | input | 1 | Level of `de_out` that means valid (0 = low) |
| cfg_hs_en | input | 2 | Bit 0: ready input used; bit 1: enable output used |
| cfg_wide | input | 1 | 0: byte units; 1: half-word units |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 32 | Host write word |
| ovr_clr | input | 1 | Clears the overrun flag |
| room4 | output | 1 | At least four bytes free |
| ovr | output | 1 | Sticky overrun flag |
| rdy_in | input | 1 | Receiver ready |
| de_out | output | 1 | Data-enable output |
| pd_out | output | 16 | Parallel data bus |

## Verification
A `pclk` level change reaches the outputs on the first system clock edge that sees the new level. Before that edge the launch register still holds the old unit. `rdy_in` is captured on the first system edge after the sampling level appears. `room4` and `ovr` settle one system clock after a write. The bench waits three system cycles after its launch toggle before it reads the bus. It holds `rdy_in` from launch through the sampling capture and scrambles it only two cycles after the sampling toggle, so a design that samples at the wrong time sees the wrong level. The bench also checks that nothing moves across the sampling edge.

// File: rtl/ptx_pkg.sv
// Package: shared widths and field positions for the parallel transmitter.
// Assumes the bus is exactly two bytes wide.
package ptx_pkg;
    localparam int BYTE_W    = 8;
    localparam int BUS_W     = 2 * BYTE_W;
    localparam int WORD_B    = 4;
    localparam int WORD_W    = WORD_B * BYTE_W;
    localparam int HS_RDY    = 0;   // handshake field bit: ready input used
    localparam int HS_DE     = 1;   // handshake field bit: enable output used

    typedef enum logic {
        UNIT_BYTE = 1'b0,
        UNIT_HALF = 1'b1
    } unit_e;
endpackage

// File: rtl/ptx_edge.sv
// Module: ptx_edge
// Finds the edges of the externally supplied parallel clock by oversampling
// it with the system clock. It turns them into one-cycle launch and sample
// strobes that follow the clock polarity bit.
// Assumes pclk is already in the clk domain and is low or high for at least
// two clk cycles per phase.
module ptx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk,
    input  logic ckpol,
    output logic launch,
    output logic sample
);
    logic pclk_q;
    logic rise;
    logic fall;

    // Keep the previous pclk level; during reset it follows pclk so that no false edge is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) pclk_q <= pclk;
        else        pclk_q <= pclk;
    end

    // Decode the edges and map them to launch/sample by polarity.
    always_comb begin
        rise   = pclk & ~pclk_q;
        fall   = ~pclk & pclk_q;
        launch = ckpol ? fall : rise;
        sample = ckpol ? rise : fall;
    end

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch && sample));
endmodule

// File: rtl/ptx_fifo.sv
// Module: ptx_fifo
// Byte queue. Takes a whole host word (WORD_B bytes) per write, and gives out
// one or two bytes per pop. Drops writes when fewer than WORD_B bytes are
// free and sets a sticky overrun flag.
// Assumes DEPTH is a power of two and at least WORD_B.
module ptx_fifo #(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8,
    parameter int WORD_B = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int WORD_W = WORD_B * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ovr_clr,
    input  logic [1:0]        pop_n,
    output logic [BYTE_W-1:0] peek0,
    output logic [BYTE_W-1:0] peek1,
    output logic [CW-1:0]     count,
    output logic              room4,
    output logic              ovr
);
    localparam int ROOM_LIM = DEPTH - WORD_B;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic              wr_ok;

    // Space check and read-side views of the oldest two bytes.
    always_comb begin
        room4 = (count <= CW'(ROOM_LIM));
        wr_ok = wr_en && room4;
        peek0 = mem[rp];
        peek1 = mem[rp + AW'(1)];
    end

    // Store each lane of an accepted word in consecutive slots.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            for (int i = 0; i < WORD_B; i++) begin
                mem[wp + AW'(i)] <= wr_data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    // Move pointers and fill count for writes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= wp + AW'(WORD_B);
            rp    <= rp + AW'(pop_n);
            count <= count + (wr_ok ? CW'(WORD_B) : CW'(0)) - CW'(pop_n);
        end
    end

    // Sticky overrun flag: set on a dropped write, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr <= 1'b0;
        else if (wr_en && !room4)  ovr <= 1'b1;
        else if (ovr_clr)          ovr <= 1'b0;
    end

    assert_fill_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count);
    assert_drop_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !room4 |=> ovr);
    assert_drop_keeps_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !room4 && pop_n == 2'd0 |=> $stable(count));
endmodule

// File: rtl/ptx_launch.sv
// Module: ptx_launch
// Bus sequencer. It holds one unit in the output register until a sampling
// edge shows that the receiver took it. It takes a new unit from the queue
// only on a launch edge, and only when none is waiting. The bus therefore
// changes together with an active enable, and never while the enable is
// inactive.
// Assumes BUS_W == 2*BYTE_W.
module ptx_launch #(
    parameter int BYTE_W = 8,
    parameter int CW     = 5,
    localparam int BUS_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              sample,
    input  logic              cfg_en,
    input  logic              cfg_rdypol,
    input  logic              cfg_depol,
    input  logic [1:0]        cfg_hs_en,
    input  ptx_pkg::unit_e    unit_mode,
    input  logic              rdy_in,
    input  logic [BYTE_W-1:0] peek0,
    input  logic [BYTE_W-1:0] peek1,
    input  logic [CW-1:0]     count,
    output logic [1:0]        pop_n,
    output logic [BUS_W-1:0]  pd_out,
    output logic              de_out
);
    import ptx_pkg::*;

    logic             valid_q;   // a unit is on the bus with enable active
    logic             acc_q;     // that unit was taken at the last sampling edge
    logic [BUS_W-1:0] data_q;
    logic             ready_ok;
    logic             unit_avail;
    logic             take;
    logic [BUS_W-1:0] next_unit;

    // Receiver readiness, queue state and the next unit to present.
    always_comb begin
        ready_ok   = !cfg_hs_en[HS_RDY] || (rdy_in == cfg_rdypol);
        unit_avail = (unit_mode == UNIT_HALF) ? (count >= CW'(2)) : (count != '0);
        take       = launch && (!valid_q || acc_q) && cfg_en && unit_avail;
        next_unit  = (unit_mode == UNIT_HALF) ? {peek1, peek0}
                                              : {{(BUS_W-BYTE_W){1'b0}}, peek0};
        pop_n      = take ? ((unit_mode == UNIT_HALF) ? 2'd2 : 2'd1) : 2'd0;
    end

    // Record at the sampling edge whether the presented unit was taken.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= 1'b0;
        else if (sample) acc_q <= valid_q && ready_ok;
        else if (launch) acc_q <= 1'b0;
    end

    // On a launch edge: re-present a stalled unit, start a new one, or go idle and hold the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (launch) begin
            if (valid_q && !acc_q) begin
                valid_q <= 1'b1;
            end else if (take) begin
                valid_q <= 1'b1;
                data_q  <= next_unit;
            end else begin
                valid_q <= 1'b0;
            end
        end
    end

    // Drive the pins; the enable sits at its inactive level when turned off.
    always_comb begin
        pd_out = data_q;
        de_out = (cfg_hs_en[HS_DE] && valid_q) ? cfg_depol : ~cfg_depol;
    end

    assert_move_on_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(data_q) && $stable(valid_q));
    assert_data_only_with_de_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> valid_q);
    assert_pop_needs_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n != 2'd0 |-> unit_avail);
    assert_stall_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch && valid_q && !acc_q |=> valid_q && $stable(data_q));
    assert_enable_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en && !valid_q |=> !valid_q);
endmodule

// File: rtl/ptx_top.sv
// Module: ptx_top
// Parallel bus transmitter with a ready input and a data-enable output.
// It connects the edge finder, the byte queue and the bus sequencer.
// Assumes the configuration inputs are changed only while in reset or idle.
module ptx_top #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pclk,
    input  logic        cfg_en,
    input  logic        cfg_ckpol,
    input  logic        cfg_rdypol,
    input  logic        cfg_depol,
    input  logic [1:0]  cfg_hs_en,
    input  logic        cfg_wide,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        ovr_clr,
    output logic        room4,
    output logic        ovr,
    input  logic        rdy_in,
    output logic        de_out,
    output logic [15:0] pd_out
);
    import ptx_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic              launch;
    logic              sample;
    logic [1:0]        pop_n;
    logic [BYTE_W-1:0] peek0;
    logic [BYTE_W-1:0] peek1;
    logic [CW-1:0]     count;
    unit_e             unit_mode;

    // Map the width bit onto the unit type.
    always_comb unit_mode = unit_e'(cfg_wide);

    ptx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pclk   (pclk),
        .ckpol  (cfg_ckpol),
        .launch (launch),
        .sample (sample)
    );

    ptx_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .WORD_B(WORD_B)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ovr_clr (ovr_clr),
        .pop_n   (pop_n),
        .peek0   (peek0),
        .peek1   (peek1),
        .count   (count),
        .room4   (room4),
        .ovr     (ovr)
    );

    ptx_launch #(.BYTE_W(BYTE_W), .CW(CW)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .sample     (sample),
        .cfg_en     (cfg_en),
        .cfg_rdypol (cfg_rdypol),
        .cfg_depol  (cfg_depol),
        .cfg_hs_en  (cfg_hs_en),
        .unit_mode  (unit_mode),
        .rdy_in     (rdy_in),
        .peek0      (peek0),
        .peek1      (peek1),
        .count      (count),
        .pop_n      (pop_n),
        .pd_out     (pd_out),
        .de_out     (de_out)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) && !rst_n |-> pd_out == 16'h0 && de_out == ~cfg_depol && !ovr && room4);
endmodule

// File: tb/sim_ptx_top.sv
// Bench: the driver tasks push the expected units into a scoreboard queue,
// and the receiver task pops and compares them at each sampling edge.
module sim_ptx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pclk = 1'b0;
    logic        cfg_en = 1'b0, cfg_ckpol = 1'b0, cfg_rdypol = 1'b0, cfg_depol = 1'b0;
    logic [1:0]  cfg_hs_en = 2'b11;
    logic        cfg_wide = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ovr_clr = 1'b0;
    logic        room4, ovr, de_out;
    logic        rdy_in = 1'b0;
    logic [15:0] pd_out;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    logic [15:0] last_d;
    bit          prev_stall;

    always #10 clk = ~clk;

    ptx_top u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset with a given configuration; the bus clock rests at its sampling level.
    task automatic do_reset(input bit ckp, input bit rp, input bit dp, input logic [1:0] hs, input bit wide);
        @(negedge clk);
        rst_n = 1'b0; cfg_en = 1'b0;
        cfg_ckpol = ckp; cfg_rdypol = rp; cfg_depol = dp; cfg_hs_en = hs; cfg_wide = wide;
        pclk = ckp;
        rdy_in = ~rp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        last_d = '0; prev_stall = 0; exp_q.delete();
    endtask

    // Host write; when it should be taken, push its units lowest first (R10).
    task automatic write_word(input logic [31:0] w, input bit taken);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        if (taken) begin
            if (cfg_wide) begin exp_q.push_back(w[15:0]); exp_q.push_back(w[31:16]); end
            else for (int i = 0; i < 4; i++) exp_q.push_back({8'h00, w[i*8 +: 8]});
        end
    endtask

    // One bus cycle as seen by the receiver: launch, observe, sampling edge, then rdy scrambled.
    task automatic pcycle(input bit ready);
        logic [15:0] d;
        logic de, de_act, ready_eff;
        rdy_in = ready ? cfg_rdypol : ~cfg_rdypol;
        pclk = ~cfg_ckpol;
        repeat (3) @(negedge clk);
        d = pd_out; de = de_out;
        de_act = (de == cfg_depol);
        ready_eff = !cfg_hs_en[0] || ready;
        if (!cfg_hs_en[1]) begin
            chk(de == ~cfg_depol, "R8 enable output off", de, ~cfg_depol);
        end else begin
            if (!cfg_en) chk(!de_act, "R13 no unit while disabled", de, ~cfg_depol);
            if (!de_act) chk(d == last_d, "R5/R3 bus holds while enable inactive", d, last_d);
            if (prev_stall) chk(de_act && d == last_d, "R6 stalled unit repeated", {de, d}, {cfg_depol, last_d});
            if (de_act && ready_eff) begin
                if (exp_q.size() == 0) chk(0, "R12 unexpected unit", d, 16'hxxxx);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(d == e, "R4/R10/R12 received unit", d, e);
                end
            end
            prev_stall = de_act && !ready_eff;
        end
        last_d = d;
        pclk = cfg_ckpol;
        repeat (2) @(negedge clk);
        rdy_in = ~rdy_in;
        @(negedge clk);
        chk(pd_out == d && de_out == de, "R2 no change on sampling edge", {de_out, pd_out}, {de, d});
    endtask

    initial begin
        int stall_k;
        // R1: reset state with active-low enable
        do_reset(0, 0, 0, 2'b11, 0);
        chk(pd_out == 16'h0, "R1 bus zero", pd_out, 0);
        chk(de_out == 1'b1, "R1 enable inactive", de_out, 1);
        chk(room4 == 1'b1 && ovr == 1'b0, "R1 flags", {room4, ovr}, 2'b10);

        // R9/R11/R13: fill while disabled, overrun, clear, then drain with stalls
        write_word(32'h03020100, 1);
        write_word(32'h07060504, 1);
        write_word(32'h0B0A0908, 1);
        chk(room4 == 1'b1, "R9 room with 12 bytes", room4, 1);
        write_word(32'h0F0E0D0C, 1);
        chk(room4 == 1'b0, "R9 full at 16 bytes", room4, 0);
        write_word(32'hDEADBEEF, 0);
        chk(ovr == 1'b1, "R11 overrun set", ovr, 1);
        repeat (3) @(negedge clk);
        chk(ovr == 1'b1, "R11 overrun sticky", ovr, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk(ovr == 1'b0, "R11 overrun cleared", ovr, 0);
        for (int i = 0; i < 4; i++) pcycle(1);
        chk(exp_q.size() == 16, "R13 nothing sent while disabled", exp_q.size(), 16);
        cfg_en = 1'b1;
        for (int i = 0; i < 26; i++) pcycle(i % 3 != 2);
        chk(exp_q.size() == 0, "R12 all bytes received", exp_q.size(), 0);
        chk(room4 == 1'b1, "R9 room after drain", room4, 1);

        // R7/R10/R2: half-word units, swapped edges and polarities
        do_reset(1, 1, 1, 2'b11, 1);
        chk(de_out == 1'b0, "R1/R7 enable inactive high-active", de_out, 0);
        cfg_en = 1'b1;
        write_word(32'hA1B2C3D4, 1);
        write_word(32'h55667788, 1);
        for (int i = 0; i < 10; i++) pcycle(i != 1 && i != 2);
        chk(exp_q.size() == 0, "R10 half-words received", exp_q.size(), 0);

        // R12: stall placed at each position around the underrun
        do_reset(0, 0, 0, 2'b11, 0);
        cfg_en = 1'b1;
        for (stall_k = 0; stall_k < 6; stall_k++) begin
            write_word(32'h40302010 + stall_k, 1);
            for (int i = 0; i < 9; i++) pcycle(i != stall_k);
            chk(exp_q.size() == 0, "R12 stall near underrun", exp_q.size(), 0);
        end
        write_word(32'hC4C3C2C1, 1);
        for (int i = 0; i < 9; i++) pcycle(i != 2 && i != 3);
        chk(exp_q.size() == 0, "R12 double stall near underrun", exp_q.size(), 0);

        // R8: ready input off; a held not-ready pin has no effect
        do_reset(0, 0, 0, 2'b10, 0);
        cfg_en = 1'b1;
        write_word(32'h99887766, 1);
        for (int i = 0; i < 7; i++) pcycle(0);
        chk(exp_q.size() == 0, "R8 ready ignored", exp_q.size(), 0);

        // R8: enable output off; pin stays inactive, data still flows
        do_reset(0, 0, 1, 2'b01, 0);
        cfg_en = 1'b1;
        write_word(32'h5A4B3C2D, 0);
        for (int i = 0; i < 7; i++) pcycle(1);
        chk(pd_out == 16'h005A, "R8 data sent with enable off", pd_out, 16'h005A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule